// File: doc/BRIEF.md
# Byte Rotate Instruction Execute Unit

This unit runs two single-word rotate instructions on an 8-bit data path. One rotates a data-memory byte one place left, with bit 7 wrapping round to bit 0, and the carry is not involved. The other rotates a byte one place right through the carry flag. The caller pulses `start` with a 16-bit instruction word, the bank register, the extended-mode enable and the current carry. The unit then walks through four phases (decode, read, process, write) and drives a banked data memory through a separate read port and write port.

Bit 9 of the instruction (d) steers the result either to the working register or back to the memory byte. Bit 8 (a) picks the fixed access bank or the bank named by the bank register. N and Z are reported on every executed rotate, and C only on the right rotate. In extended mode, an operand address that would need indexed-offset addressing is not executed; the unit raises `unsup` in its place. Any other opcode runs through the phases and does nothing.

Top module: `rot_exec`

## Requirements
- R1: During and right after reset, `busy`, `rd_en`, `wr_en`, `w_we`, `nz_we`, `c_we` and `unsup` are all 0.
- R2: Opcode bits [15:10] = 010001 rotate left without carry: result = {x[6:0], x[7]} for operand x, and `c_we` stays 0 (carry unchanged); for example 8'hAB gives 8'h57.
- R3: Opcode bits [15:10] = 001100 rotate right through carry: result = {C, x[7:1]}, `c_we` = 1 and `c_out` = x[0]; for example 8'hE6 with C=0 gives 8'h73 and C=0.
- R4: With bit 9 (d) = 0 the result appears on `w_out` with `w_we` = 1 and `wr_en` = 0 (memory untouched). With d = 1, `wr_en` = 1, `wr_data` holds the result, `wr_addr` equals the address that was read, and `w_we` = 0.
- R5: With bit 8 (a) = 1 the operand address is {bsr[3:0], f}, where f = instr[7:0].
- R6: With a = 0 the operand address is {4'h0, f} for f < 8'h60 and {4'hF, f} for f >= 8'h60.
- R7: A `start` accepted while idle gives `busy` for exactly four cycles. `rd_en` rises in the second of those cycles. The result strobes appear in the fourth, and `busy` is 0 in the next cycle. A `start` seen while busy is ignored.
- R8: When `ext_en` = 1, a = 0 and f <= 8'h5F, a rotate instruction raises `unsup` in the fourth cycle. In that case there is no read, no write and no flag strobe. With a = 1, or with f >= 8'h60, it executes normally.
- R9: An instruction whose bits [15:10] are neither 010001 nor 001100 causes no read, no write, no flag strobe and no `unsup`.
- R10: On an executed rotate, `nz_we` = 1, `n_out` = result bit 7 and `z_out` = 1 exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank register |
| ext_en | input | 1 | Extended instruction mode enabled |
| c_in | input | 1 | Current carry flag |
| busy | output | 1 | Instruction in progress |
| rd_en | output | 1 | Data memory read strobe |
| rd_addr | output | 12 | Data memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Data memory write strobe |
| wr_addr | output | 12 | Data memory write address |
| wr_data | output | 8 | Data memory write data |
| w_we | output | 1 | Working register write strobe |
| w_out | output | 8 | Rotate result |
| nz_we | output | 1 | N and Z flag update strobe |
| n_out | output | 1 | New N flag |
| z_out | output | 1 | New Z flag |
| c_we | output | 1 | Carry update strobe |
| c_out | output | 1 | New carry flag |
| unsup | output | 1 | Unsupported indexed-mode indication |

## Verification
A bad phase counter shows up within one instruction. Read or write strobes move away from the second or fourth busy cycle, or a second read appears on a `start` that should have been ignored. A badly latched opcode, destination bit or address shows up in the same fourth cycle: the wrong strobe rises, or the read address or write address differs from the bank mapping. A stale carry or operand register gives a wrong rotate result or wrong flags. The sweep across every operand value, both rotates, both destinations, both bank modes and both carries catches these on the first affected pattern.

// File: rtl/rot_exec.sv
module rot_exec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [3:0]  bsr,
  input  logic        ext_en,
  input  logic        c_in,
  output logic        busy,
  output logic        rd_en,
  output logic [11:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        wr_en,
  output logic [11:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        w_we,
  output logic [7:0]  w_out,
  output logic        nz_we,
  output logic        n_out,
  output logic        z_out,
  output logic        c_we,
  output logic        c_out
  ,output logic       unsup
);
  localparam logic [5:0] OP_RL = 6'b010001;
  localparam logic [5:0] OP_RR = 6'b001100;
  localparam logic [7:0] ACC_SPLIT = 8'h60;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_RD, S_PROC, S_WR} phase_t;
  typedef enum logic [1:0] {K_NONE, K_RL, K_RR, K_UNSUP} kind_t;

  phase_t      ph;
  kind_t       kind_q, kind_d;
  logic [15:0] ir_q;
  logic [3:0]  bsr_q;
  logic        ext_q, c_q;
  logic [11:0] addr_q, addr_d;
  logic [7:0]  res_q, res_d;
  logic        cres_q;

  wire [7:0] f   = ir_q[7:0];
  wire       d   = ir_q[9];
  wire       a   = ir_q[8];
  wire       rot = (ir_q[15:10] == OP_RL) || (ir_q[15:10] == OP_RR);
  wire       exec = (kind_q == K_RL) || (kind_q == K_RR);

  always_comb begin
    if (!rot)                            kind_d = K_NONE;
    else if (ext_q && !a && f < ACC_SPLIT) kind_d = K_UNSUP;
    else if (ir_q[15:10] == OP_RL)       kind_d = K_RL;
    else                                 kind_d = K_RR;
    if (a)                 addr_d = {bsr_q, f};
    else if (f < ACC_SPLIT) addr_d = {4'h0, f};
    else                   addr_d = {4'hF, f};
    res_d = (kind_q == K_RL) ? {rd_data[6:0], rd_data[7]} : {c_q, rd_data[7:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      kind_q <= K_NONE;
      ir_q   <= '0;
      bsr_q  <= '0;
      ext_q  <= 1'b0;
      c_q    <= 1'b0;
      addr_q <= '0;
      res_q  <= '0;
      cres_q <= 1'b0;
    end else begin
      case (ph)
        S_IDLE: if (start) begin
          ph    <= S_DEC;
          ir_q  <= instr;
          bsr_q <= bsr;
          ext_q <= ext_en;
          c_q   <= c_in;
        end
        S_DEC: begin
          ph     <= S_RD;
          kind_q <= kind_d;
          addr_q <= addr_d;
        end
        S_RD: ph <= S_PROC;
        S_PROC: begin
          ph     <= S_WR;
          res_q  <= res_d;
          cres_q <= rd_data[0];
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  wire in_wr = (ph == S_WR);

  assign busy    = (ph != S_IDLE);
  assign rd_en   = (ph == S_RD) && exec;
  assign rd_addr = addr_q;
  assign wr_en   = in_wr && exec && d;
  assign wr_addr = addr_q;
  assign wr_data = res_q;
  assign w_we    = in_wr && exec && !d;
  assign w_out   = res_q;
  assign nz_we   = in_wr && exec;
  assign n_out   = res_q[7];
  assign z_out   = (res_q == 8'h00);
  assign c_we    = in_wr && (kind_q == K_RR);
  assign c_out   = cres_q;
  assign unsup   = in_wr && (kind_q == K_UNSUP);
endmodule

module rot_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_en,
  input logic [11:0] rd_addr,
  input logic        wr_en,
  input logic [11:0] wr_addr,
  input logic        w_we,
  input logic        nz_we,
  input logic        c_we,
  input logic        unsup
);
  assert_one_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_we && wr_en));
  assert_wr_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == $past(rd_addr, 2)));
  assert_strobe_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nz_we |-> $past(rd_en, 2));
  assert_read_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  assert_unsup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> (!w_we && !wr_en && !nz_we && !c_we && !$past(rd_en, 2)));
  assert_carry_with_nz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> nz_we);
endmodule

bind rot_exec rot_exec_chk u_chk (.*);

// File: tb/rot_exec_bench.sv
module rot_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, ext_en = 0, c_in = 0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic [7:0]  rd_data, op_val = '0;
  logic        busy, rd_en, wr_en, w_we, nz_we, n_out, z_out, c_we, c_out, unsup;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0]  wr_data, w_out;

  int checks = 0, failures = 0, rd_cnt = 0;
  logic [11:0] rd_seen;

  rot_exec u_rot_exec (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= op_val;
      rd_seen <= rd_addr;
      rd_cnt  <= rd_cnt + 1;
    end
  end

  logic s_rd_q2, s_busy_q1, s_busy_end, s_quiet_end;
  logic s_wwe, s_wren, s_nzwe, s_cwe, s_c, s_n, s_z, s_unsup;
  logic [7:0] s_w, s_wd;
  logic [11:0] s_wa;
  int rd_before;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, input logic [3:0] b, input logic e,
                     input logic c, input logic [7:0] v, input bit hold);
    instr = ins; bsr = b; ext_en = e; c_in = c; op_val = v; start = 1;
    rd_before = rd_cnt;
    @(negedge clk);
    if (!hold) start = 0; else instr = ~ins;
    s_busy_q1 = busy;
    @(negedge clk);
    s_rd_q2 = rd_en;
    @(negedge clk);
    @(negedge clk);
    s_wwe = w_we; s_wren = wr_en; s_nzwe = nz_we; s_cwe = c_we; s_c = c_out;
    s_n = n_out; s_z = z_out; s_unsup = unsup; s_w = w_out; s_wd = wr_data; s_wa = wr_addr;
    @(negedge clk);
    start = 0;
    s_busy_end = busy;
    s_quiet_end = !(rd_en || wr_en || w_we || nz_we || c_we || unsup);
  endtask

  function automatic logic [11:0] exp_addr(input logic a, input logic [3:0] b, input logic [7:0] f);
    if (a) return {b, f};
    return (f < 8'h60) ? {4'h0, f} : {4'hF, f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !rd_en && !wr_en && !w_we && !nz_we && !c_we && !unsup, "R1 reset idle", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !rd_en && !wr_en && !w_we && !nz_we && !c_we && !unsup, "R1 after reset", busy, 0);

    run({6'b010001, 1'b1, 1'b1, 8'h20}, 4'h3, 0, 0, 8'hAB, 0);
    check(s_wren && s_wd == 8'h57, "R2 AB rotates to 57", s_wd, 8'h57);
    run({6'b001100, 1'b0, 1'b1, 8'h20}, 4'h3, 0, 0, 8'hE6, 0);
    check(s_wwe && !s_wren && s_w == 8'h73 && s_cwe && !s_c, "R3 E6 gives 73 C0", s_w, 8'h73);

    for (int op = 0; op < 2; op++)
      for (int v = 0; v < 256; v++)
        for (int m = 0; m < 8; m++) begin
          logic d, a, c; logic [7:0] f, er; logic [3:0] b; logic [11:0] ea; logic ec;
          d = m[0]; a = m[1]; c = m[2];
          f = 8'((v * 37 + m * 11) % 256);
          b = 4'((v + m) % 16);
          ea = exp_addr(a, b, f);
          if (op == 0) begin er = {v[6:0], v[7]}; ec = 0; end
          else begin er = {c, v[7:1]}; ec = v[0]; end
          run({(op == 0) ? 6'b010001 : 6'b001100, d, a, f}, b, 0, c, 8'(v), 0);
          if (op == 0) check(s_w == er && !s_cwe, "R2 rotate left", s_w, er);
          else         check(s_w == er && s_cwe && s_c == ec, "R3 rotate right carry", {s_cwe, s_c, s_w}, {1'b1, ec, er});
          check(s_nzwe && s_n == er[7] && s_z == (er == 0), "R10 N Z flags", {s_nzwe, s_n, s_z}, {1'b1, er[7], er == 0});
          check(s_wwe == !d && s_wren == d && (!d || s_wa == ea), "R4 destination", {s_wwe, s_wren, s_wa}, {!d, d, ea});
          if (a) check(rd_seen == ea, "R5 banked address", rd_seen, ea);
          else   check(rd_seen == ea, "R6 access address", rd_seen, ea);
          check(s_busy_q1 && s_rd_q2 && !s_busy_end && s_quiet_end && rd_cnt == rd_before + 1,
                "R7 phase timing", rd_cnt - rd_before, 1);
        end

    for (int a = 0; a < 2; a++)
      for (int f = 0; f < 256; f++) begin
        bit exp_un;
        exp_un = (a == 0) && (f <= 8'h5F);
        run({6'b001100, 1'b1, 1'(a), 8'(f)}, 4'h5, 1, 1, 8'h5A, 0);
        check(s_unsup == exp_un && s_nzwe == !exp_un && s_wren == !exp_un && s_cwe == !exp_un &&
              rd_cnt == rd_before + (exp_un ? 0 : 1), "R8 indexed mode", {s_unsup, s_nzwe}, {exp_un, !exp_un});
      end

    for (int o = 0; o < 64; o++) begin
      if (o == 6'b010001 || o == 6'b001100) continue;
      run({6'(o), 1'b1, 1'b0, 8'h77}, 4'h1, 0, 1, 8'hFF, 0);
      check(!s_wwe && !s_wren && !s_nzwe && !s_cwe && !s_unsup && rd_cnt == rd_before,
            "R9 other opcode", {s_wwe, s_wren, s_nzwe, s_cwe, s_unsup}, 0);
    end

    run({6'b010001, 1'b0, 1'b1, 8'h10}, 4'h2, 0, 0, 8'h81, 1);
    check(s_wwe && s_w == 8'h03, "R7 held start first result", s_w, 8'h03);
    rd_before = rd_cnt;
    repeat (4) @(negedge clk);
    check(!busy && rd_cnt == rd_before, "R7 start while busy ignored", rd_cnt - rd_before, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule